// File: doc/BRIEF.md
# CEC Received-Frame Queue

This block queues complete CEC frames between a message-level receive engine and a host. The engine offers each finished frame on a wide push port in one cycle. That frame carries the header byte, the opcode byte, up to fourteen operand bytes, an operand count and a flag that marks a frame received with an error. The queue holds up to `DEPTH` frames in arrival order. The host sees only the frame at the head, through byte-wide read registers.

The host first reads a frame-information register. This register packs three values: the operand count of the head frame, the number of frames waiting, and the head frame's error flag. The host then reads the header, opcode and operand registers, or skips them when the error flag is set. To remove the head frame it writes the control register. A second control encoding empties the whole queue. Both operations run for a fixed number of cycles (`OP_CYCLES`, default two), and their control bits read back as 1 for that whole time.

Two sticky status bits feed a single interrupt line. One reports that a frame is available. The other reports that a frame was dropped because the queue was full. The host clears each bit by writing 1 to it.

Top module: `cecrx_fifo`

## Requirements
- R1: After reset, the frame-information register (0x00), the control register (0x0C), both status registers (0x10, 0x14) and `irq` all read 0.
- R2: The frame-information register holds the head frame's operand count in bits 3:0, the number of queued frames (0 to DEPTH) in bits 6:4 and the head frame's error flag in bit 7. All three fields are 0 when the queue is empty.
- R3: The head frame's header byte reads at 0x04 and its opcode at 0x08. Operand byte i (i = 0..13, taken from `push_opnd[8i+7:8i]`) reads at 0x40 + 4*i. Any other address reads 0.
- R4: Frames leave the queue in the order in which they were pushed.
- R5: Writing a value with bit 0 = 1 and bit 1 = 0 to 0x0C starts a pop. Control bit 0 reads 1 for OP_CYCLES cycles after the write edge, then the head frame is removed and the register reads 0. A pop on an empty queue changes nothing.
- R6: Writing 0x3 to 0x0C starts a flush. Bits 1:0 read 0x3 for OP_CYCLES cycles, then every frame is removed. A frame pushed on the completing edge is discarded and does not set the overrun bit.
- R7: A control write made while a pop or flush is in progress is ignored.
- R8: A push made while DEPTH frames are held is dropped, the queue contents are unchanged, and status bit 0 at 0x14 (overrun) is set.
- R9: Status bit 1 at 0x10 (frame available) is set when a push is accepted, and again when a pop completes with frames still queued.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and the clear write occur on the same edge, the bit stays set.
- R11: `irq` is high exactly while the frame-available bit or the overrun bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Receive engine offers a complete frame this cycle |
| push_hdr | input | 8 | Header byte of the offered frame |
| push_opc | input | 8 | Opcode byte of the offered frame |
| push_len | input | 4 | Operand byte count, 0 to 14 |
| push_err | input | 1 | Frame was received with an error |
| push_opnd | input | 112 | Operand bytes, byte i in bits 8i+7:8i |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, OR of the two status bits |

## Verification
The hardest cases to reach are collisions between an operation in progress and a new event. These include a control write landing in the middle of a pop, a push landing on the exact edge where a flush completes, and a status clear landing on the same edge as a set event. The bench drives every input on the falling edge, so it can count rising edges from the control write and place the second stimulus on a chosen edge. The overrun case uses the same approach: the queue is filled to DEPTH and a fifth frame is pushed. The bench then checks that every frame survives unchanged.

// File: rtl/cecrx_pkg.sv
package cecrx_pkg;

  localparam int MAX_OPND = 14;

  localparam logic [7:0] A_INFO  = 8'h00;
  localparam logic [7:0] A_HDR   = 8'h04;
  localparam logic [7:0] A_OPC   = 8'h08;
  localparam logic [7:0] A_CTRL  = 8'h0C;
  localparam logic [7:0] A_STAT0 = 8'h10;
  localparam logic [7:0] A_STAT1 = 8'h14;
  localparam logic [7:0] A_OPND  = 8'h40;

  localparam int NE_BIT  = 1;  // frame-available bit in status 0
  localparam int OVR_BIT = 0;  // overrun bit in status 1

  typedef struct packed {
    logic                    err;
    logic [3:0]              len;
    logic [7:0]              hdr;
    logic [7:0]              opc;
    logic [MAX_OPND*8-1:0]   opnd;
  } frame_t;

  // Pack the frame-information register.
  function automatic logic [7:0] pack_info(input logic err,
                                           input logic [2:0] frames,
                                           input logic [3:0] len);
    return {err, frames, len};
  endfunction

  // True when the address selects one of the word-spaced operand slots.
  function automatic logic opnd_hit(input logic [7:0] a);
    logic [7:0] off;
    off = a - A_OPND;
    return (a >= A_OPND) && (off[1:0] == 2'b00) && (off < 8'(4 * MAX_OPND));
  endfunction

  // Operand slot index addressed by a.
  function automatic logic [3:0] opnd_idx(input logic [7:0] a);
    logic [7:0] off;
    off = a - A_OPND;
    return off[5:2];
  endfunction

endpackage

// File: rtl/cecrx_seq.sv
module cecrx_seq #(
  parameter int OP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wbit0,
  input  logic wbit1,
  output logic busy,
  output logic is_flush,
  output logic pop_done,
  output logic flush_done
);
  localparam int TW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  logic [TW-1:0] tmr;
  logic          start;
  logic          done;

  assign start = wr_ctrl && !busy && wbit0;
  assign done  = busy && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_flush <= 1'b0;
      tmr      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      is_flush <= wbit1;
      tmr      <= TW'(OP_CYCLES - 1);
    end else if (done) begin
      busy     <= 1'b0;
      is_flush <= 1'b0;
    end else if (busy) begin
      tmr      <= tmr - 1'b1;
    end
  end

  assign pop_done   = done && !is_flush;
  assign flush_done = done &&  is_flush;

endmodule

// File: rtl/cecrx_store.sv
module cecrx_store
  import cecrx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid,
  input  frame_t                        push_frame,
  input  logic                          pop_done,
  input  logic                          flush_done,
  output frame_t                        head,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          full,
  output logic                          push_acc,
  output logic                          pop_eff
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t           mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign push_acc = push_valid && !full && !flush_done;
  assign pop_eff  = pop_done && (count != '0);
  assign head     = (count != '0) ? mem[rptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush_done) begin
      rptr  <= wptr;
      count <= '0;
    end else begin
      if (push_acc) wptr <= nxt(wptr);
      if (pop_eff)  rptr <= nxt(rptr);
      count <= count + CNT_W'(push_acc) - CNT_W'(pop_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wptr] <= push_frame;
  end

endmodule

// File: rtl/cecrx_stat.sv
module cecrx_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic ne_set,
  input  logic ovr_set,
  input  logic ne_clr,
  input  logic ovr_clr,
  output logic ne_q,
  output logic ovr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (ne_set)       ne_q  <= 1'b1;
      else if (ne_clr)  ne_q  <= 1'b0;
      if (ovr_set)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cecrx_fifo.sv
module cecrx_fifo
  import cecrx_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int OP_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_valid,
  input  logic [7:0]            push_hdr,
  input  logic [7:0]            push_opc,
  input  logic [3:0]            push_len,
  input  logic                  push_err,
  input  logic [MAX_OPND*8-1:0] push_opnd,
  input  logic [7:0]            reg_addr,
  input  logic                  reg_we,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  output logic                  irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  frame_t           push_frame;
  frame_t           head;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             push_acc;
  logic             pop_eff;
  logic             busy;
  logic             is_flush;
  logic             pop_done;
  logic             flush_done;
  logic             ne_q;
  logic             ovr_q;
  logic             ne_set;
  logic             ovr_set;
  logic             wr_ctrl;

  assign push_frame = '{err: push_err, len: push_len, hdr: push_hdr,
                        opc: push_opc, opnd: push_opnd};
  assign wr_ctrl    = reg_we && (reg_addr == A_CTRL);

  cecrx_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wbit0      (reg_wdata[0]),
    .wbit1      (reg_wdata[1]),
    .busy       (busy),
    .is_flush   (is_flush),
    .pop_done   (pop_done),
    .flush_done (flush_done)
  );

  cecrx_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_frame (push_frame),
    .pop_done   (pop_done),
    .flush_done (flush_done),
    .head       (head),
    .count      (count),
    .full       (full),
    .push_acc   (push_acc),
    .pop_eff    (pop_eff)
  );

  assign ne_set  = push_acc || (pop_eff && (count >= CNT_W'(2)));
  assign ovr_set = push_valid && full && !flush_done;

  cecrx_stat u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ne_set  (ne_set),
    .ovr_set (ovr_set),
    .ne_clr  (reg_we && (reg_addr == A_STAT0) && reg_wdata[NE_BIT]),
    .ovr_clr (reg_we && (reg_addr == A_STAT1) && reg_wdata[OVR_BIT]),
    .ne_q    (ne_q),
    .ovr_q   (ovr_q)
  );

  assign irq = ne_q | ovr_q;

  always_comb begin
    reg_rdata = '0;
    if (opnd_hit(reg_addr)) begin
      reg_rdata = head.opnd[opnd_idx(reg_addr)*8 +: 8];
    end else begin
      case (reg_addr)
        A_INFO:  reg_rdata = pack_info(head.err, 3'(count), head.len);
        A_HDR:   reg_rdata = head.hdr;
        A_OPC:   reg_rdata = head.opc;
        A_CTRL:  reg_rdata = {6'b0, busy && is_flush, busy};
        A_STAT0: reg_rdata = 8'(ne_q) << NE_BIT;
        A_STAT1: reg_rdata = 8'(ovr_q) << OVR_BIT;
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cecrx_fifo_chk.sv
module cecrx_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             full,
  input logic             push_acc,
  input logic             pop_done,
  input logic             flush_done,
  input logic [CNT_W-1:0] count,
  input logic             busy,
  input logic             ne_q,
  input logic             ovr_q
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2

  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done && (count != '0) && !push_acc |=> count == $past(count) - 1'b1); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> count == '0); // R6

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pop_done && !flush_done |=> busy); // R7

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_acc); // R8

  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !flush_done |=> ovr_q); // R8

  AST_AVAIL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> ne_q); // R9
endmodule

bind cecrx_fifo cecrx_fifo_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .full       (full),
  .push_acc   (push_acc),
  .pop_done   (pop_done),
  .flush_done (flush_done),
  .count      (count),
  .busy       (busy),
  .ne_q       (ne_q),
  .ovr_q      (ovr_q)
);

// File: tb/cecrx_fifo_test.sv
`timescale 1ns/1ps
module cecrx_fifo_test;
  localparam logic [7:0] INFO = 8'h00, HDR = 8'h04, OPC = 8'h08, CTRL = 8'h0C;
  localparam logic [7:0] ST0 = 8'h10, ST1 = 8'h14, OPB = 8'h40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         push_valid;
  logic [7:0]   push_hdr, push_opc;
  logic [3:0]   push_len;
  logic         push_err;
  logic [111:0] push_opnd;
  logic [7:0]   reg_addr, reg_wdata, reg_rdata;
  logic         reg_we;
  logic         irq;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  cecrx_fifo uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_hdr(push_hdr),
    .push_opc(push_opc), .push_len(push_len), .push_err(push_err),
    .push_opnd(push_opnd), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] o, input logic [3:0] l,
                      input logic e, input logic [7:0] seed);
    push_hdr = h; push_opc = o; push_len = l; push_err = e;
    for (int i = 0; i < 14; i++) push_opnd[i*8 +: 8] = seed + 8'(i);
  endtask

  task automatic push(input logic [7:0] h, input logic [7:0] o, input logic [3:0] l,
                      input logic e, input logic [7:0] seed);
    @(negedge clk);
    load(h, o, l, e, seed);
    push_valid = 1'b1;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop();
    wr(CTRL, 8'h01);
    step(); step();
  endtask

  task automatic head_is(input string req, input logic [7:0] h, input logic [7:0] o,
                         input logic [3:0] l, input logic e, input logic [7:0] seed,
                         input logic [2:0] frames);
    rdchk(req, INFO, {e, frames, l});
    rdchk(req, HDR, h);
    rdchk(req, OPC, o);
    for (int i = 0; i < int'(l); i++) rdchk(req, OPB + 8'(4 * i), seed + 8'(i));
  endtask

  task automatic t_reset();
    rdchk("R1 info", INFO, 8'h00);
    rdchk("R1 ctrl", CTRL, 8'h00);
    rdchk("R1 st0", ST0, 8'h00);
    rdchk("R1 st1", ST1, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_order();
    push(8'h4F, 8'h82, 4'd3, 1'b0, 8'hA0);
    push(8'h05, 8'h36, 4'd0, 1'b1, 8'h00);
    push(8'h10, 8'h9C, 4'd14, 1'b0, 8'h30);
    head_is("R2 R3 R4 first frame", 8'h4F, 8'h82, 4'd3, 1'b0, 8'hA0, 3'd3);
    rdchk("R3 unmapped operand slot", 8'h78, 8'h00);
    rdchk("R3 unmapped register", 8'h18, 8'h00);
    rdchk("R9 avail after push", ST0, 8'h02);
    chk("R11 irq with avail", {7'b0, irq}, 8'h01);
    wr(ST0, 8'h02);
    rdchk("R10 avail cleared", ST0, 8'h00);
    chk("R11 irq low", {7'b0, irq}, 8'h00);
    wr(CTRL, 8'h01);
    rdchk("R5 pop busy cycle 1", CTRL, 8'h01);
    rdchk("R5 head kept during pop", HDR, 8'h4F);
    step();
    rdchk("R5 pop busy cycle 2", CTRL, 8'h01);
    step();
    rdchk("R5 pop done", CTRL, 8'h00);
    rdchk("R9 avail re-raised", ST0, 8'h02);
    head_is("R2 R4 error frame", 8'h05, 8'h36, 4'd0, 1'b1, 8'h00, 3'd2);
    wr(ST0, 8'h02);
    pop();
    head_is("R3 R4 full-length frame", 8'h10, 8'h9C, 4'd14, 1'b0, 8'h30, 3'd1);
    wr(ST0, 8'h02);
    pop();
    rdchk("R2 empty info", INFO, 8'h00);
    rdchk("R9 no avail when empty", ST0, 8'h00);
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 4; k++) push(8'h10 + 8'(k), 8'h44, 4'd1, 1'b0, 8'(k));
    rdchk("R8 no overrun at depth", ST1, 8'h00);
    push(8'hEE, 8'h44, 4'd2, 1'b1, 8'h77);
    rdchk("R8 overrun set", ST1, 8'h01);
    rdchk("R8 count stays at depth", INFO, 8'h41);
    wr(ST0, 8'h02);
    chk("R11 irq from overrun", {7'b0, irq}, 8'h01);
    wr(ST1, 8'h00);
    rdchk("R10 zero write keeps overrun", ST1, 8'h01);
    wr(ST1, 8'h01);
    rdchk("R10 overrun cleared", ST1, 8'h00);
    chk("R11 irq cleared", {7'b0, irq}, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rdchk("R8 R4 stored frame intact", HDR, 8'h10 + 8'(k));
      rdchk("R8 stored operand intact", OPB, 8'(k));
      pop();
    end
    rdchk("R8 dropped frame absent", INFO, 8'h00);
    wr(ST0, 8'h02);
  endtask

  task automatic t_flush();
    for (int k = 0; k < 3; k++) push(8'h20 + 8'(k), 8'h11, 4'd2, 1'b0, 8'h50);
    wr(CTRL, 8'h03);
    rdchk("R6 flush busy cycle 1", CTRL, 8'h03);
    step();
    rdchk("R6 flush busy cycle 2", CTRL, 8'h03);
    step();
    rdchk("R6 flush done", CTRL, 8'h00);
    rdchk("R6 queue empty", INFO, 8'h00);
    push(8'h31, 8'h22, 4'd1, 1'b0, 8'h60);
    wr(CTRL, 8'h03);
    step();
    load(8'h32, 8'h22, 4'd1, 1'b0, 8'h61);
    push_valid = 1'b1;
    step();
    push_valid = 1'b0;
    rdchk("R6 push on completing edge dropped", INFO, 8'h00);
    rdchk("R6 no overrun from flush edge", ST1, 8'h00);
    wr(ST0, 8'h02);
  endtask

  task automatic t_busy_ignore();
    push(8'h21, 8'h01, 4'd0, 1'b0, 8'h00);
    push(8'h22, 8'h02, 4'd0, 1'b0, 8'h00);
    wr(CTRL, 8'h01);
    reg_addr = CTRL; reg_wdata = 8'h03; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
    rdchk("R7 flush write ignored mid pop", CTRL, 8'h01);
    step();
    rdchk("R7 pop finished", CTRL, 8'h00);
    rdchk("R7 only one frame removed", INFO, 8'h10);
    rdchk("R7 next frame at head", HDR, 8'h22);
    pop();
    wr(ST0, 8'h02);
  endtask

  task automatic t_pop_empty();
    wr(CTRL, 8'h01);
    rdchk("R5 empty pop busy", CTRL, 8'h01);
    step(); step();
    rdchk("R5 empty pop done", CTRL, 8'h00);
    rdchk("R5 empty pop no effect", INFO, 8'h00);
    rdchk("R9 empty pop no avail", ST0, 8'h00);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    load(8'h3A, 8'h55, 4'd0, 1'b0, 8'h00);
    push_valid = 1'b1;
    reg_addr = ST0; reg_wdata = 8'h02; reg_we = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; reg_we = 1'b0;
    rdchk("R10 set beats clear", ST0, 8'h02);
    rdchk("R10 frame accepted", INFO, 8'h10);
    pop();
    wr(ST0, 8'h02);
    rdchk("R10 final clear", ST0, 8'h00);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push_valid = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    load(8'h00, 8'h00, 4'd0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_overrun();
    t_flush();
    t_busy_ignore();
    t_pop_empty();
    t_set_wins();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule